// File: doc/BRIEF.md
# Lamp Driver Auto-Retry Controller

This block is the digital control for a protected low-side lamp or LED driver. A synchronous command bit asks for the lamp to be lit. The block answers with a gate enable for the external output transistor. When the gate is enabled, the transistor pulls the lamp terminal low and the lamp lights. Current limiting, the flyback clamp and the analog comparators sit outside the block. They reach it as plain flags: a raw over-current/short flag, an over-temperature flag, and supply over-voltage and under-voltage flags.

A cold filament draws a large surge when it is first switched on. For that reason every turn-on starts with a long inrush blanking window, and during that window the over-current flag is ignored. Once blanking ends, a short must persist for a filter time before it counts as qualified. A qualified short switches the gate off and starts a retry timer. When the timer expires, the lamp is switched on again, with fresh blanking, if the command is still high. No fault is reported, and no open-load check is made.

The thermal and supply flags override the command. Over-temperature and over-voltage hold the gate off only while they are present. Under-voltage is stricter: after it clears, the gate stays off until the command has been seen low once. All pins are plain control levels. There is no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `lamp_retry_ctl`

## Requirements
- R1: `gate_en` is 0 while `rst_n` is low (asynchronous), and it is 0 from the first clock edge at which `cmd_on` is sampled low.
- R2: With no inhibiting flag, `gate_en` becomes 1 at the first clock edge that samples `cmd_on` high while the lamp is off.
- R3: For BLANK_CYC clock edges after each turn-on, `oc_raw` has no effect and the gate stays enabled.
- R4: After blanking, `oc_raw` sampled high on FILT_CYC consecutive edges turns the gate off at the last of those edges. A single low sample restarts the count.
- R5: RETRY_CYC edges after a short shutdown, the gate is re-enabled if `cmd_on` is high and nothing inhibits. This starts a fresh blanking window. Otherwise the gate stays off. The retry wait runs to completion even if `cmd_on` drops.
- R6: `ot_flag` high turns the gate off at the next edge, whatever the command. After it clears, the gate turns on again at the next edge if `cmd_on` is high.
- R7: `ov_flag` high turns the gate off at the next edge. After it clears, the gate restores its commanded state at the next edge.
- R8: `uv_flag` high turns the gate off. After it clears, the gate stays off until `cmd_on` has been sampled low with `uv_flag` low. Only then does a high command enable it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Lamp command, 1 = lamp requested on |
| oc_raw | input | 1 | Raw over-current/short comparator flag |
| ot_flag | input | 1 | Over-temperature flag |
| ov_flag | input | 1 | Supply over-voltage flag |
| uv_flag | input | 1 | Supply under-voltage flag |
| gate_en | output | 1 | Output transistor gate enable, 1 = lamp pulled low (on) |

## Verification
The hardest case to bring about is a second short right after an automatic retry. Over-current must be ignored for the whole fresh blanking window and must then still trip after the filter count. The stimulus holds `oc_raw` high straight through a retry and the blanking that follows it. It also breaks a short with a single low cycle, which shows that the filter count restarts instead of adding up. Timing parameters are scaled down in the bench, so that retry, blanking and filter boundaries can be sampled on exact edges.

// File: rtl/lamp_ctl_pkg.sv
package lamp_ctl_pkg;
  typedef enum logic [1:0] {
    LS_OFF   = 2'd0,
    LS_BLANK = 2'd1,
    LS_ON    = 2'd2,
    LS_RETRY = 2'd3
  } lamp_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/lamp_supply_guard.sv
module lamp_supply_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic ot_flag,
  input  logic ov_flag,
  input  logic uv_flag,
  output logic inhibit
);
  logic uv_lock_q;

  // Under-voltage lock: set by the flag, released only by a low command once the flag is gone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      uv_lock_q <= 1'b0;
    else if (uv_flag)
      uv_lock_q <= 1'b1;
    else if (!cmd_on)
      uv_lock_q <= 1'b0;
  end

  assign inhibit = ot_flag | ov_flag | uv_flag | uv_lock_q;

  assert_uv_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag && cmd_on) |=> inhibit);
endmodule

// File: rtl/lamp_cycle_timer.sv
module lamp_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clear)
      cnt_q <= '0;
    else if (!done)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == (limit - 1'b1));

  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear) |=> (cnt_q == $past(cnt_q)) || clear);
endmodule

// File: rtl/lamp_seq_fsm.sv
module lamp_seq_fsm
  import lamp_ctl_pkg::*;
#(
  parameter int BLANK_CYC = 350000,
  parameter int FILT_CYC  = 3000,
  parameter int RETRY_CYC = 500000,
  parameter int W         = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_on,
  input  logic         oc_raw,
  input  logic         inhibit,
  input  logic         tmr_done,
  output logic         tmr_clear,
  output logic [W-1:0] tmr_limit,
  output logic         gate_en
);
  localparam logic [W-1:0] LIM_BLANK = W'(BLANK_CYC);
  localparam logic [W-1:0] LIM_FILT  = W'(FILT_CYC);
  localparam logic [W-1:0] LIM_RETRY = W'(RETRY_CYC);

  lamp_state_e state_q, state_d;
  logic        want_on;

  assign want_on = cmd_on && !inhibit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_OFF:   if (want_on) state_d = LS_BLANK;
      LS_BLANK: begin
        if (!want_on)      state_d = LS_OFF;
        else if (tmr_done) state_d = LS_ON;
      end
      LS_ON: begin
        if (!want_on)                state_d = LS_OFF;
        else if (oc_raw && tmr_done) state_d = LS_RETRY;
      end
      LS_RETRY: if (tmr_done) state_d = want_on ? LS_BLANK : LS_OFF;
      default:  state_d = LS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LS_OFF;
    else        state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      LS_BLANK: tmr_limit = LIM_BLANK;
      LS_ON:    tmr_limit = LIM_FILT;
      default:  tmr_limit = LIM_RETRY;
    endcase
  end

  // Restart the count on every state change; in ON it counts only consecutive over-current cycles
  assign tmr_clear = (state_d != state_q) || (state_q == LS_OFF) ||
                     ((state_q == LS_ON) && !oc_raw);

  assign gate_en = (state_q == LS_BLANK) || (state_q == LS_ON);

  assert_turn_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_OFF && cmd_on && !inhibit) |=> gate_en);
  assert_blank_no_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_BLANK) |=> (state_q != LS_RETRY));
  assert_filter_consecutive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_ON && !oc_raw) |=> (state_q != LS_RETRY));
  assert_retry_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_RETRY && tmr_done && cmd_on && !inhibit) |=> (state_q == LS_BLANK));
endmodule

// File: rtl/lamp_retry_ctl.sv
module lamp_retry_ctl
  import lamp_ctl_pkg::*;
#(
  parameter int BLANK_CYC = 350000,
  parameter int FILT_CYC  = 3000,
  parameter int RETRY_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic oc_raw,
  input  logic ot_flag,
  input  logic ov_flag,
  input  logic uv_flag,
  output logic gate_en
);
  localparam int W = $clog2(max3(BLANK_CYC, FILT_CYC, RETRY_CYC) + 1);

  logic         inhibit;
  logic         tmr_clear;
  logic         tmr_done;
  logic [W-1:0] tmr_limit;

  lamp_supply_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_on  (cmd_on),
    .ot_flag (ot_flag),
    .ov_flag (ov_flag),
    .uv_flag (uv_flag),
    .inhibit (inhibit)
  );

  lamp_cycle_timer #(.W(W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  lamp_seq_fsm #(
    .BLANK_CYC (BLANK_CYC),
    .FILT_CYC  (FILT_CYC),
    .RETRY_CYC (RETRY_CYC),
    .W         (W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_on    (cmd_on),
    .oc_raw    (oc_raw),
    .inhibit   (inhibit),
    .tmr_done  (tmr_done),
    .tmr_clear (tmr_clear),
    .tmr_limit (tmr_limit),
    .gate_en   (gate_en)
  );

  assert_cmd_low_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on |=> !gate_en);
  assert_overtemp_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |=> !gate_en);
  assert_overvolt_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |=> !gate_en);
  assert_undervolt_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> !gate_en);
endmodule

// File: tb/tb_lamp_retry_ctl.sv
`timescale 1ns/1ps
module tb_lamp_retry_ctl;
  localparam int BLANK = 20;
  localparam int FILT  = 5;
  localparam int RETRY = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_on = 1'b0, oc_raw = 1'b0, ot_flag = 1'b0, ov_flag = 1'b0, uv_flag = 1'b0;
  logic gate_en;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lamp_retry_ctl #(.BLANK_CYC(BLANK), .FILT_CYC(FILT), .RETRY_CYC(RETRY)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .oc_raw(oc_raw),
    .ot_flag(ot_flag), .ov_flag(ov_flag), .uv_flag(uv_flag), .gate_en(gate_en)
  );

  // Vector: [17:13] {cmd,oc,ot,ov,uv}, [12:5] edges to hold, [4] expected gate, [3:0] requirement
  localparam int NV = 29;
  localparam logic [17:0] VEC [NV] = '{
    {5'b00000, 8'd3,  1'b0, 4'd1},  // R1 idle off
    {5'b10000, 8'd1,  1'b1, 4'd2},  // R2 one-edge turn-on
    {5'b11000, 8'd15, 1'b1, 4'd3},  // R3 over-current in blanking
    {5'b11000, 8'd8,  1'b1, 4'd3},  // R3 blanking ends, filter 3 of 5
    {5'b11000, 8'd2,  1'b0, 4'd4},  // R4 fifth over-current edge trips
    {5'b10000, 8'd28, 1'b0, 4'd5},  // R5 retry not yet expired
    {5'b10000, 8'd2,  1'b1, 4'd5},  // R5 retry expires, gate back
    {5'b11000, 8'd19, 1'b1, 4'd5},  // R5 fresh blanking after retry
    {5'b11000, 8'd5,  1'b1, 4'd4},  // R4 filter 4 of 5
    {5'b11000, 8'd1,  1'b0, 4'd4},  // R4 trip again
    {5'b00000, 8'd29, 1'b0, 4'd5},  // R5 command dropped during retry
    {5'b00000, 8'd3,  1'b0, 4'd5},  // R5 expiry with command low stays off
    {5'b10000, 8'd1,  1'b1, 4'd2},  // R2 turn-on from off
    {5'b10100, 8'd1,  1'b0, 4'd6},  // R6 over-temperature off
    {5'b10100, 8'd10, 1'b0, 4'd6},  // R6 held off
    {5'b10000, 8'd1,  1'b1, 4'd6},  // R6 resume
    {5'b10010, 8'd4,  1'b0, 4'd7},  // R7 over-voltage off
    {5'b10000, 8'd1,  1'b1, 4'd7},  // R7 restored
    {5'b10001, 8'd3,  1'b0, 4'd8},  // R8 under-voltage off
    {5'b10000, 8'd10, 1'b0, 4'd8},  // R8 stays off after clearing
    {5'b00000, 8'd2,  1'b0, 4'd8},  // R8 command low releases lock
    {5'b10000, 8'd1,  1'b1, 4'd8},  // R8 on again after release
    {5'b00000, 8'd1,  1'b0, 4'd1},  // R1 command low off
    {5'b10000, 8'd21, 1'b1, 4'd3},  // R3 full blanking elapsed
    {5'b11000, 8'd4,  1'b1, 4'd4},  // R4 four over-current edges
    {5'b10000, 8'd1,  1'b1, 4'd4},  // R4 one low edge restarts filter
    {5'b11000, 8'd4,  1'b1, 4'd4},  // R4 four more, no trip
    {5'b11000, 8'd1,  1'b0, 4'd4},  // R4 fifth consecutive trips
    {5'b00000, 8'd35, 1'b0, 4'd5}   // R5 retry ends with command low
  };

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (gate_en !== exp) begin
      failures++;
      $display("FAIL R%0d %s: gate_en=%b expected=%b", req, what, gate_en, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(1'b0, 1, "reset state R1");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {cmd_on, oc_raw, ot_flag, ov_flag, uv_flag} = VEC[i][17:13];
      repeat (int'(VEC[i][12:5])) @(negedge clk);
      check(VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R1 asynchronous reset while lit
    {cmd_on, oc_raw, ot_flag, ov_flag, uv_flag} = 5'b10000;
    @(negedge clk);
    check(1'b1, 2, "on before reset R2");
    #3 rst_n = 1'b0;
    #1 check(1'b0, 1, "async reset R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b1, 2, "on after reset release R2");

    // R1 command low during blanking
    cmd_on = 1'b0;
    @(negedge clk);
    check(1'b0, 1, "cmd low in blanking R1");

    // R6 over-temperature during a retry wait: expiry goes off, clearing turns on fresh
    cmd_on = 1'b1;
    repeat (BLANK + 1) @(negedge clk);
    oc_raw = 1'b1;
    repeat (FILT) @(negedge clk);
    check(1'b0, 4, "short trip R4");
    oc_raw = 1'b0; ot_flag = 1'b1;
    repeat (RETRY + 2) @(negedge clk);
    check(1'b0, 6, "over-temp holds through retry R6");
    ot_flag = 1'b0;
    @(negedge clk);
    check(1'b1, 6, "resume after over-temp R6");

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule